// File: doc/BRIEF.md
# Chained DMA Command Word Engine

This block is one channel of a descriptor-driven DMA engine. Software builds a linked list of command descriptors in memory and raises a semaphore. The engine then fetches each descriptor over a simple memory read port. It writes the descriptor's inline register words to a peripheral register port. Next it moves the data the command asks for, either from memory to the peripheral or from the peripheral to memory. Finally it follows the chain to the next descriptor or returns to idle.

A descriptor is a run of 32-bit words at consecutive byte addresses. At offset 0 is the next-descriptor pointer. At offset 4, the low half holds the control field and the high half holds the byte count. At offset 8 is the buffer address. From offset 12 come zero to fifteen inline peripheral register words. Control field bits: [1:0] command (0 no transfer, 1 peripheral-to-memory, 2 memory-to-peripheral, 3 sense, which is handled as no transfer); [2] chain; [3] interrupt on completion; [6] semaphore decrement; [7] wait for the peripheral's end signal; [15:12] count of inline register words. Bits 8 and 9 (terminate handling) and bits 11:10 and 5:4 are carried but ignored. Data moves as whole 32-bit words, so the engine transfers ceil(bytes/4) words.

The states are IDLE, HDR (fetch the three header words), PIO (fetch and write inline register words), XRD (memory read, pushed to the peripheral), XIN (wait for a peripheral word), XWR (memory write), WAITE (wait for the end signal) and DONE (completion pulses). The transitions are: IDLE→HDR when the semaphore is nonzero; HDR→PIO when words are listed, otherwise HDR→XRD/XIN/WAITE/DONE; PIO→XRD/XIN/WAITE/DONE after the last word; XRD→WAITE/DONE after the last word; XIN→XWR on a peripheral word; XWR→XIN, or XWR→WAITE/DONE on the last word; WAITE→DONE on the end signal; DONE→HDR when chain is set, otherwise DONE→IDLE. A read error in HDR, PIO or XRD, or an over-limit byte count found in HDR, goes straight to IDLE.

Top module: `cmd_chain_engine`

## Requirements
- R1: While the semaphore count is zero and the engine is idle, no memory read is requested.
- R2: A command starts by reading the words at start_ptr, start_ptr+4 and start_ptr+8, in that order. A pending read request holds its address until the read is accepted.
- R3: The N inline register words (control bits [15:12]) are read from offset 12 onward and written to the register port with index 0..N-1 in order, before any data moves. N=0 writes none. At most one of register write, peripheral push, peripheral request and memory write is active in a cycle.
- R4: Command 2 reads ceil(bytes/4) words starting at the buffer address, in ascending order, and presents each on per_out_data with a one-cycle per_out_valid.
- R5: Command 1 requests ceil(bytes/4) peripheral words and writes each to buffer address + 4·k. A pending memory write holds its address and data until acknowledged.
- R6: Commands 0 and 3, and any command with a byte count of 0, move no data.
- R7: With control bit 2 set, the next descriptor is fetched from the next pointer after completion. With it clear, the engine returns to idle.
- R8: With control bit 3 set, irq pulses for exactly one cycle at completion. With it clear, irq stays low.
- R9: A sem_inc pulse raises sem_count by one. A completed command with control bit 6 set pulses sem_dec and lowers sem_count by one. With bit 6 clear the count is unchanged.
- R10: With control bit 7 set, completion (irq and sem_dec) waits until per_end is asserted.
- R11: A read error aborts the command, sets fault (held until reset) and returns the engine to idle without completion pulses.
- R12: A byte count above MAX_BYTES (0xFF00 by default) sets fault before any register write or data movement. Exactly MAX_BYTES is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_ptr | input | AW | Address of the first descriptor, sampled on leaving idle |
| sem_inc | input | 1 | Semaphore increment pulse |
| sem_count | output | SEMW | Current semaphore count |
| sem_dec | output | 1 | Semaphore decrement pulse at completion |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| mem_rd_err | input | 1 | Read error, qualified by mem_rd_valid |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Memory write accepted |
| pio_wr | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Peripheral register index |
| pio_data | output | 32 | Peripheral register data |
| per_out_valid | output | 1 | Word pushed to the peripheral |
| per_out_data | output | 32 | Word pushed to the peripheral |
| per_in_req | output | 1 | Engine wants a word from the peripheral |
| per_in_valid | input | 1 | Peripheral word present |
| per_in_data | input | 32 | Peripheral word |
| per_end | input | 1 | Peripheral end-of-transfer |
| irq | output | 1 | Completion interrupt pulse |
| fault | output | 1 | Bus error or over-limit count seen |

## Verification
Every output is combinational from the state register and the current handshake inputs. A register write, a peripheral push or a memory write is therefore visible in the same cycle that the responder presents valid or ack, and it is consumed at the next rising edge. sem_count changes one edge after sem_inc or sem_dec. fault is set at the edge that consumes the offending read. The bench responders drive handshakes on the falling edge and log the outputs 1 ns later, which is the window the next rising edge samples. Totals are compared only after a settling window longer than the slowest command. The wait-for-end case is checked both before and after per_end.

// File: rtl/cce_pkg.sv
`timescale 1ns/1ps
package cce_pkg;
    localparam int CB_CHAIN = 2;
    localparam int CB_IRQ   = 3;
    localparam int CB_DEC   = 6;
    localparam int CB_WAIT  = 7;
    localparam int CB_PIO_L = 12;

    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_TOMEM = 2'd1;
    localparam logic [1:0] CMD_FRMEM = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PIO,
        ST_XRD,
        ST_XIN,
        ST_XWR,
        ST_WAITE,
        ST_DONE
    } cce_state_e;
endpackage

// File: rtl/cce_sema.sv
`timescale 1ns/1ps
module cce_sema #(
    parameter int SEMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SEMW-1:0] count,
    output logic            nonzero
);
    localparam logic [SEMW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && count != TOP) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign nonzero = (count != '0);
endmodule

// File: rtl/cce_decode.sv
`timescale 1ns/1ps
module cce_decode import cce_pkg::*; #(
    parameter int MAX_BYTES = 16'hFF00,
    parameter int WCW       = 14
) (
    input  logic [15:0]    ctrl,
    input  logic [15:0]    bytes,
    output logic           mv_frmem,
    output logic           mv_tomem,
    output logic           chain,
    output logic           irq_en,
    output logic           dec_en,
    output logic           wait_end,
    output logic [3:0]     pio_n,
    output logic [WCW-1:0] words,
    output logic           over_limit
);
    logic [16:0] byte_sum;
    logic        unused_bits;

    assign mv_frmem   = (ctrl[1:0] == CMD_FRMEM);
    assign mv_tomem   = (ctrl[1:0] == CMD_TOMEM);
    assign chain      = ctrl[CB_CHAIN];
    assign irq_en     = ctrl[CB_IRQ];
    assign dec_en     = ctrl[CB_DEC];
    assign wait_end   = ctrl[CB_WAIT];
    assign pio_n      = ctrl[CB_PIO_L +: 4];
    assign byte_sum   = {1'b0, bytes} + 17'd3;
    assign words      = WCW'(byte_sum >> 2);
    assign over_limit = ({16'd0, bytes} > 32'(MAX_BYTES));
    assign unused_bits = ^{ctrl[11:8], ctrl[5:4]};
endmodule

// File: rtl/cmd_chain_engine.sv
`timescale 1ns/1ps
module cmd_chain_engine import cce_pkg::*; #(
    parameter int AW        = 32,
    parameter int SEMW      = 8,
    parameter int MAX_BYTES = 16'hFF00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   start_ptr,
    input  logic            sem_inc,
    output logic [SEMW-1:0] sem_count,
    output logic            sem_dec,
    output logic            mem_rd_req,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [31:0]     mem_rd_data,
    input  logic            mem_rd_err,
    output logic            mem_wr_req,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [31:0]     mem_wr_data,
    input  logic            mem_wr_ack,
    output logic            pio_wr,
    output logic [3:0]      pio_idx,
    output logic [31:0]     pio_data,
    output logic            per_out_valid,
    output logic [31:0]     per_out_data,
    output logic            per_in_req,
    input  logic            per_in_valid,
    input  logic [31:0]     per_in_data,
    input  logic            per_end,
    output logic            irq,
    output logic            fault
);
    localparam int WCW = $clog2((MAX_BYTES + 3) / 4 + 1);
    localparam logic [AW-1:0] PIO_OFS = AW'(12);

    cce_state_e     st, st_nx, data_nx, fin_nx;
    logic [AW-1:0]  ptr, nxt_ptr, buf_addr;
    logic [15:0]    ctrl, bytes;
    logic [3:0]     widx;
    logic [WCW-1:0] cnt;
    logic [31:0]    data_q;
    logic           sem_nz;

    logic           d_frmem, d_tomem, d_chain, d_irq, d_dec, d_wait, d_over;
    logic [3:0]     d_pio_n;
    logic [WCW-1:0] d_words;
    logic           rd_ok, rd_bad, cnt_last, pio_last, hdr_last;

    cce_sema #(.SEMW(SEMW)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (sem_inc),
        .dec     (sem_dec),
        .count   (sem_count),
        .nonzero (sem_nz)
    );

    cce_decode #(.MAX_BYTES(MAX_BYTES), .WCW(WCW)) u_dec (
        .ctrl       (ctrl),
        .bytes      (bytes),
        .mv_frmem   (d_frmem),
        .mv_tomem   (d_tomem),
        .chain      (d_chain),
        .irq_en     (d_irq),
        .dec_en     (d_dec),
        .wait_end   (d_wait),
        .pio_n      (d_pio_n),
        .words      (d_words),
        .over_limit (d_over)
    );

    assign rd_ok    = mem_rd_valid && !mem_rd_err;
    assign rd_bad   = mem_rd_valid && mem_rd_err;
    assign cnt_last = (cnt == d_words - WCW'(1));
    assign pio_last = (widx == d_pio_n - 4'd1);
    assign hdr_last = (widx == 4'd2);

    // where a command goes once its header or register words are done
    always_comb begin
        fin_nx = d_wait ? ST_WAITE : ST_DONE;
        if (d_frmem && d_words != '0) begin
            data_nx = ST_XRD;
        end else if (d_tomem && d_words != '0) begin
            data_nx = ST_XIN;
        end else begin
            data_nx = fin_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (sem_nz) st_nx = ST_HDR;
            ST_HDR: begin
                if (rd_bad) begin
                    st_nx = ST_IDLE;
                end else if (rd_ok && hdr_last) begin
                    if (d_over)                st_nx = ST_IDLE;
                    else if (d_pio_n != 4'd0)  st_nx = ST_PIO;
                    else                       st_nx = data_nx;
                end
            end
            ST_PIO: begin
                if (rd_bad)                    st_nx = ST_IDLE;
                else if (rd_ok && pio_last)    st_nx = data_nx;
            end
            ST_XRD: begin
                if (rd_bad)                    st_nx = ST_IDLE;
                else if (rd_ok && cnt_last)    st_nx = fin_nx;
            end
            ST_XIN:   if (per_in_valid) st_nx = ST_XWR;
            ST_XWR:   if (mem_wr_ack) st_nx = cnt_last ? fin_nx : ST_XIN;
            ST_WAITE: if (per_end) st_nx = ST_DONE;
            ST_DONE:  st_nx = d_chain ? ST_HDR : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            nxt_ptr  <= '0;
            buf_addr <= '0;
            ctrl     <= '0;
            bytes    <= '0;
            widx     <= '0;
            cnt      <= '0;
            data_q   <= '0;
            fault    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (sem_nz) begin
                        ptr  <= start_ptr;
                        widx <= '0;
                    end
                end
                ST_HDR: begin
                    if (rd_bad) begin
                        fault <= 1'b1;
                    end else if (rd_ok) begin
                        unique case (widx)
                            4'd0:    nxt_ptr <= AW'(mem_rd_data);
                            4'd1: begin
                                ctrl  <= mem_rd_data[15:0];
                                bytes <= mem_rd_data[31:16];
                            end
                            default: buf_addr <= AW'(mem_rd_data);
                        endcase
                        widx <= hdr_last ? 4'd0 : widx + 4'd1;
                        cnt  <= '0;
                        if (hdr_last && d_over) fault <= 1'b1;
                    end
                end
                ST_PIO: begin
                    if (rd_bad)     fault <= 1'b1;
                    else if (rd_ok) widx <= widx + 4'd1;
                end
                ST_XRD: begin
                    if (rd_bad)     fault <= 1'b1;
                    else if (rd_ok) cnt <= cnt + WCW'(1);
                end
                ST_XIN:   if (per_in_valid) data_q <= per_in_data;
                ST_XWR:   if (mem_wr_ack) cnt <= cnt + WCW'(1);
                ST_WAITE: ;
                ST_DONE: begin
                    if (d_chain) begin
                        ptr  <= nxt_ptr;
                        widx <= '0;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_req    = 1'b0;
        mem_rd_addr   = '0;
        mem_wr_req    = 1'b0;
        pio_wr        = 1'b0;
        per_out_valid = 1'b0;
        per_in_req    = 1'b0;
        irq           = 1'b0;
        sem_dec       = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_HDR: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = ptr + AW'({widx, 2'b00});
            end
            ST_PIO: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = ptr + PIO_OFS + AW'({widx, 2'b00});
                pio_wr      = rd_ok;
            end
            ST_XRD: begin
                mem_rd_req    = 1'b1;
                mem_rd_addr   = buf_addr + AW'({cnt, 2'b00});
                per_out_valid = rd_ok;
            end
            ST_XIN:   per_in_req = 1'b1;
            ST_XWR:   mem_wr_req = 1'b1;
            ST_WAITE: ;
            ST_DONE: begin
                irq     = d_irq;
                sem_dec = d_dec;
            end
        endcase
    end

    assign mem_wr_addr  = buf_addr + AW'({cnt, 2'b00});
    assign mem_wr_data  = data_q;
    assign pio_idx      = widx;
    assign pio_data     = mem_rd_data;
    assign per_out_data = mem_rd_data;
endmodule

// File: rtl/cce_chk.sv
`timescale 1ns/1ps
module cce_chk #(
    parameter int AW   = 32,
    parameter int SEMW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sem_inc,
    input logic [SEMW-1:0] sem_count,
    input logic            sem_dec,
    input logic            mem_rd_req,
    input logic [AW-1:0]   mem_rd_addr,
    input logic            mem_rd_valid,
    input logic            mem_wr_req,
    input logic [AW-1:0]   mem_wr_addr,
    input logic [31:0]     mem_wr_data,
    input logic            mem_wr_ack,
    input logic            pio_wr,
    input logic            per_out_valid,
    input logic            per_in_req,
    input logic            irq,
    input logic            fault
);
    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_one_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pio_wr, per_out_valid, per_in_req, mem_wr_req}));

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_sem_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_dec && !sem_inc && sem_count != '0) |=>
            (sem_count == $past(sem_count) - 1'b1));

    assert_fault_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(mem_rd_valid));
endmodule

bind cmd_chain_engine cce_chk #(.AW(AW), .SEMW(SEMW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sem_inc      (sem_inc),
    .sem_count    (sem_count),
    .sem_dec      (sem_dec),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .pio_wr       (pio_wr),
    .per_out_valid(per_out_valid),
    .per_in_req   (per_in_req),
    .irq          (irq),
    .fault        (fault)
);

// File: tb/tb_cmd_chain_engine.sv
`timescale 1ns/1ps
module tb_cmd_chain_engine;
    localparam int AW = 32;
    localparam int SEMW = 8;
    localparam logic [31:0] BUF = 32'h800;
    localparam int WD_LIMIT = 150000;

    // vector: cmd[22:21], pio count[20:17], bytes[16:1], irq[0]; all with decrement set
    localparam logic [22:0] VEC [7] = '{
        {2'd2, 4'd3,  16'd16, 1'b1},
        {2'd1, 4'd0,  16'd10, 1'b1},
        {2'd0, 4'd2,  16'd8,  1'b1},
        {2'd3, 4'd1,  16'd12, 1'b0},
        {2'd2, 4'd0,  16'd0,  1'b1},
        {2'd1, 4'd15, 16'd4,  1'b1},
        {2'd2, 4'd0,  16'd13, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] start_ptr = 32'h100;
    logic sem_inc = 1'b0;
    logic [SEMW-1:0] sem_count;
    logic sem_dec;
    logic mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic mem_rd_err = 1'b0;
    logic mem_wr_req;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic mem_wr_ack = 1'b0;
    logic pio_wr;
    logic [3:0] pio_idx;
    logic [31:0] pio_data;
    logic per_out_valid;
    logic [31:0] per_out_data;
    logic per_in_req;
    logic per_in_valid = 1'b0;
    logic [31:0] per_in_data = '0;
    logic per_end = 1'b0;
    logic irq;
    logic fault;

    cmd_chain_engine #(.AW(AW), .SEMW(SEMW)) dut (
        .clk(clk), .rst_n(rst_n), .start_ptr(start_ptr), .sem_inc(sem_inc),
        .sem_count(sem_count), .sem_dec(sem_dec),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack),
        .pio_wr(pio_wr), .pio_idx(pio_idx), .pio_data(pio_data),
        .per_out_valid(per_out_valid), .per_out_data(per_out_data),
        .per_in_req(per_in_req), .per_in_valid(per_in_valid), .per_in_data(per_in_data),
        .per_end(per_end), .irq(irq), .fault(fault)
    );

    always #2.5 clk = ~clk;

    logic [31:0] mem [0:511];
    logic [31:0] err_addr = 32'hFFFF_FFFC;
    int in_k;
    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_rd, n_acc, n_pio, n_out, n_wr, n_irq, out_bad, wr_bad, order_bad;
    logic [31:0] rd_log [64];
    logic [3:0]  pio_log_idx [64];
    logic [31:0] pio_log_dat [64];

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        if (a >= BUF) return 32'hB000_0000 + ((a - BUF) >> 2);
        return mem[a[10:2]];
    endfunction

    // responders: present handshakes on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0; mem_rd_err = 1'b0;
            mem_wr_ack = 1'b0; per_in_valid = 1'b0; in_k = 0;
        end else begin
            if (mem_rd_req && !mem_rd_valid) begin
                mem_rd_valid = 1'b1;
                mem_rd_err   = (mem_rd_addr == err_addr);
                mem_rd_data  = rd_model(mem_rd_addr);
            end else begin
                mem_rd_valid = 1'b0; mem_rd_err = 1'b0;
            end
            mem_wr_ack = mem_wr_req && !mem_wr_ack;
            if (per_in_req && !per_in_valid) begin
                per_in_valid = 1'b1;
                per_in_data  = 32'hD000_0000 + in_k;
                in_k++;
            end else begin
                per_in_valid = 1'b0;
            end
        end
    end

    // monitor: 1 ns after the falling edge, i.e. what the next rising edge samples
    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            n_rd = 0; n_acc = 0; n_pio = 0; n_out = 0; n_wr = 0; n_irq = 0;
            out_bad = 0; wr_bad = 0; order_bad = 0;
        end else begin
            if (mem_rd_req) n_rd++;
            if (mem_rd_req && mem_rd_valid) begin
                if (n_acc < 64) rd_log[n_acc] = mem_rd_addr;
                n_acc++;
            end
            if (pio_wr) begin
                if (n_pio < 64) begin
                    pio_log_idx[n_pio] = pio_idx;
                    pio_log_dat[n_pio] = pio_data;
                end
                if (n_out + n_wr > 0) order_bad++;
                n_pio++;
            end
            if (per_out_valid) begin
                if (per_out_data !== 32'hB000_0000 + n_out) out_bad++;
                n_out++;
            end
            if (mem_wr_req && mem_wr_ack) begin
                if (mem_wr_addr !== BUF + 4 * n_wr || mem_wr_data !== 32'hD000_0000 + n_wr)
                    wr_bad++;
                n_wr++;
            end
            if (irq) n_irq++;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err_addr = 32'hFFFF_FFFC;
        start_ptr = 32'h100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk);
        sem_inc = 1'b1;
        @(negedge clk);
        sem_inc = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk_ctrl(input logic [1:0] cmd, input logic chain,
            input logic irq_b, input logic dec_b, input logic wait_b, input logic [3:0] npio);
        return {npio, 4'b0000, wait_b, dec_b, 2'b00, irq_b, chain, cmd};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [15:0] c,
            input logic [15:0] nb, input int npio, input logic [31:0] pbase);
        mem[a[10:2]]      = nxt;
        mem[a[10:2] + 1]  = {nb, c};
        mem[a[10:2] + 2]  = BUF;
        for (int i = 0; i < npio; i++) mem[a[10:2] + 3 + i] = pbase + i;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        do_reset();

        // reset state
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        chk("R11 reset fault", {31'd0, fault}, 32'd0);
        chk("R9 reset sem_count", 32'(sem_count), 32'd0);

        // R1: no semaphore, no activity
        put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1), 16'd8, 1, 32'hA000_0000);
        wait_cyc(60);
        chk("R1 idle without semaphore reads", n_rd, 0);

        // vector table
        for (int v = 0; v < 7; v++) begin
            automatic logic [1:0]  cmd = VEC[v][22:21];
            automatic logic [3:0]  np  = VEC[v][20:17];
            automatic logic [15:0] nb  = VEC[v][16:1];
            automatic logic        ie  = VEC[v][0];
            automatic int exp_w = (cmd == 2'd1 || cmd == 2'd2) ? (int'(nb) + 3) / 4 : 0;
            automatic int bad = 0;
            do_reset();
            put_desc(32'h100, 32'h0, mk_ctrl(cmd, 1'b0, ie, 1'b1, 1'b0, np), nb, int'(np), 32'hA000_0000);
            kick();
            chk("R9 sem_inc raises count", 32'(sem_count), 32'd1);
            wait_cyc(400);
            if (rd_log[0] !== 32'h100 || rd_log[1] !== 32'h104 || rd_log[2] !== 32'h108) bad++;
            chk("R2 header fetch order", bad, 0);
            bad = 0;
            for (int i = 0; i < int'(np); i++)
                if (pio_log_idx[i] !== 4'(i) || pio_log_dat[i] !== 32'hA000_0000 + i) bad++;
            chk("R3 register word count", n_pio, int'(np));
            chk("R3 register word index/data", bad, 0);
            chk("R3 register words before data", order_bad, 0);
            if (cmd == 2'd2) begin
                chk("R4 words pushed to peripheral", n_out, exp_w);
                chk("R4 pushed data", out_bad, 0);
            end else if (cmd == 2'd1) begin
                chk("R5 words written to memory", n_wr, exp_w);
                chk("R5 written address/data", wr_bad, 0);
            end else begin
                chk("R6 no data for command 0/3", n_out + n_wr, 0);
            end
            if (exp_w == 0) chk("R6 no data moved", n_out + n_wr, 0);
            chk("R8 irq pulses", n_irq, ie ? 1 : 0);
            chk("R9 semaphore decremented", 32'(sem_count), 32'd0);
            chk("R7 stop after unchained command", n_acc, 3 + int'(np) + ((cmd == 2'd2) ? exp_w : 0));
        end

        // R7: two chained descriptors
        do_reset();
        put_desc(32'h100, 32'h180, mk_ctrl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1), 16'd0, 1, 32'hA000_0000);
        put_desc(32'h180, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2), 16'd8, 2, 32'hC000_0000);
        kick();
        wait_cyc(300);
        chk("R7 next descriptor address", rd_log[4], 32'h180);
        chk("R7 register words over chain", n_pio, 3);
        chk("R7 second descriptor word", pio_log_dat[2], 32'hC000_0001);
        chk("R7 data of second descriptor", n_out, 2);
        chk("R8 single irq for chain", n_irq, 1);
        chk("R9 count after chain", 32'(sem_count), 32'd0);

        // R10: wait for end signal
        do_reset();
        put_desc(32'h100, 32'h0, mk_ctrl(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0), 16'd0, 0, 32'h0);
        kick();
        wait_cyc(100);
        chk("R10 no irq before end", n_irq, 0);
        chk("R10 semaphore held before end", 32'(sem_count), 32'd1);
        per_end = 1'b1;
        @(negedge clk);
        per_end = 1'b0;
        wait_cyc(10);
        chk("R10 irq after end", n_irq, 1);
        chk("R10 semaphore after end", 32'(sem_count), 32'd0);

        // R9: decrement bit clear leaves the count unchanged
        do_reset();
        put_desc(32'h100, 32'h0, mk_ctrl(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0), 16'd0, 0, 32'h0);
        kick();
        wait_cyc(100);
        chk("R9 count kept without decrement", 32'(sem_count), 32'd1);

        // R11: error on a data read
        do_reset();
        err_addr = BUF;
        put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0), 16'd8, 0, 32'h0);
        kick();
        wait_cyc(100);
        chk("R11 fault on data read error", {31'd0, fault}, 32'd1);
        chk("R11 no data after error", n_out, 0);
        chk("R11 no completion after error", n_irq, 0);

        // R11: error on a header read
        do_reset();
        err_addr = 32'h104;
        put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2), 16'd8, 2, 32'hA000_0000);
        kick();
        wait_cyc(100);
        chk("R11 fault on header error", {31'd0, fault}, 32'd1);
        chk("R11 no register write after error", n_pio, 0);

        // R12: over-limit count
        do_reset();
        put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2), 16'hFF04, 2, 32'hA000_0000);
        kick();
        wait_cyc(100);
        chk("R12 fault on count above limit", {31'd0, fault}, 32'd1);
        chk("R12 no register write", n_pio, 0);
        chk("R12 no data", n_out, 0);

        // R12: count exactly at the limit
        do_reset();
        put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0), 16'hFF00, 0, 32'h0);
        kick();
        wait_cyc(33000);
        chk("R12 limit count accepted", {31'd0, fault}, 32'd0);
        chk("R12 limit word count", n_out, 32'h3FC0);
        chk("R4 limit data", out_bad, 0);
        chk("R8 limit irq", n_irq, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule